// File: doc/BRIEF.md
# Quad DAC Parallel Write Port

This block is the host-side write port for four digital-to-analog converter channels. A host writes over a parallel bus that has an active-low chip select, an active-low write strobe, a three-bit channel address and a 14-bit data bus. One write either replaces a whole 14-bit channel word, or, in byte mode, fills one half of a right-justified word. The low half is 8 bits wide. The high half is 6 bits wide and is carried on the low data lines.

The bus pins are asynchronous to the block clock, so they pass through a synchronizer first. A write takes effect once the rising edge of the write strobe is seen, using the bus values that were sampled while the strobe was still low. Each accepted write updates the selected channel register and raises a one-cycle strobe that names the channel. Downstream logic uses that strobe to decide when to move the new word into the converter.

Top module: `dac_quad_loader`

## Requirements
- R1: After reset, all four channel words are 0 and `wr_stb` is low.
- R2: With `byte_mode` low, a write with `cs_n` low loads all 14 bits of `din` into the channel selected by `chan_addr`.
- R3: With `byte_mode` high and `hi_sel` low, a write loads `din[7:0]` into bits 7..0 of the selected word. Bits 13..8 of that word keep their value, and `din[13:8]` has no effect.
- R4: With `byte_mode` high and `hi_sel` high, a write loads `din[5:0]` into bits 13..8 of the selected word. Bits 7..0 of that word keep their value, and `din[13:6]` has no effect.
- R5: A write to a `chan_addr` value from 4 to 7 changes no word and raises no strobe.
- R6: A write strobe pulse while `cs_n` is high changes no word and raises no strobe.
- R7: Each accepted write raises `wr_stb` for exactly one clock, with `wr_chan` equal to `chan_addr[1:0]`. The updated word is visible in the same cycle as the strobe, on the third rising clock edge after `wr_n` rises.
- R8: A write changes only the addressed channel word. The other three words keep their values.
- R9: Holding `wr_n` low for any length of time produces no write. A single low-to-high transition of `wr_n` produces exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; the write happens on its rising edge |
| chan_addr | input | 3 | Channel address; only values 0 to 3 are accepted |
| byte_mode | input | 1 | 0 = full 14-bit write, 1 = half-word write |
| hi_sel | input | 1 | In byte mode: 0 = low 8 bits, 1 = high 6 bits |
| din | input | 14 | Write data bus |
| dac_words | output | 56 | Channel words; channel c occupies bits [14c+13:14c] |
| wr_stb | output | 1 | One-cycle pulse for each accepted write |
| wr_chan | output | 2 | Channel of the most recent accepted write |

## Verification
The bench builds the block with its default parameters: 14-bit words split 8/6, four channels, a three-bit address and a two-stage synchronizer. The three-bit address lets the bench reach the four out-of-range addresses. The 8/6 split lets it place deliberately unused bits on `din` during half-word writes and confirm they are dropped. The two-stage synchronizer fixes the three-edge write latency that the scoreboard relies on when it pairs each strobe with the expected channel and word.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
    // Which part of a channel word a write targets
    typedef enum logic [1:0] {
        FLD_FULL = 2'd0,
        FLD_LO   = 2'd1,
        FLD_HI   = 2'd2
    } fld_e;
endpackage

// File: rtl/dacld_sync.sv
module dacld_sync #(
    parameter int              WB      = 8,
    parameter int              STAGES  = 2,
    parameter logic [WB-1:0]   RST_VAL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WB-1:0] d_in,
    output logic [WB-1:0] d_out
);
    logic [STAGES-1:0][WB-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign d_out = st_q[STAGES-1];
endmodule

// File: rtl/dacld_decode.sv
module dacld_decode
    import dacld_pkg::*;
#(
    parameter int DW  = 14,
    parameter int AW  = 3,
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH),
    localparam int WB  = 4 + AW + DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [WB-1:0]  smp,
    output logic           ev_vld,
    output logic [CHW-1:0] ev_chan,
    output fld_e           ev_fld,
    output logic [DW-1:0]  ev_data
);
    typedef struct packed {
        logic          wr_n;
        logic          cs_n;
        logic          bmode;
        logic          hsel;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } smp_t;

    typedef struct packed {
        smp_t prev;
    } st_t;

    st_t  st_d, st_q;
    smp_t cur;
    logic rise, in_range;

    always_comb begin
        cur       = smp_t'(smp);
        st_d.prev = cur;
        // the bus values sampled in the last cycle the strobe was low
        rise      = cur.wr_n && !st_q.prev.wr_n;
        in_range  = int'(st_q.prev.addr) < NCH;
        ev_vld    = rise && !st_q.prev.cs_n && in_range;
        ev_chan   = st_q.prev.addr[CHW-1:0];
        ev_data   = st_q.prev.data;
        if (!st_q.prev.bmode)    ev_fld = FLD_FULL;
        else if (st_q.prev.hsel) ev_fld = FLD_HI;
        else                     ev_fld = FLD_LO;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    // R9: one strobe edge yields one event, never two in a row
    p_single_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vld |=> !ev_vld);
endmodule

// File: rtl/dacld_bank.sv
module dacld_bank
    import dacld_pkg::*;
#(
    parameter int DW   = 14,
    parameter int LO_W = 8,
    parameter int NCH  = 4,
    localparam int CHW  = $clog2(NCH),
    localparam int HI_W = DW - LO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_vld,
    input  logic [CHW-1:0]     ev_chan,
    input  fld_e               ev_fld,
    input  logic [DW-1:0]      ev_data,
    output logic [NCH*DW-1:0]  words,
    output logic               stb,
    output logic [CHW-1:0]     chan
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] word;
        logic                   stb;
        logic [CHW-1:0]         chan;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = ev_vld;
        if (ev_vld) st_d.chan = ev_chan;
        for (int c = 0; c < NCH; c++) begin
            if (ev_vld && ev_chan == CHW'(c)) begin
                case (ev_fld)
                    FLD_LO:  st_d.word[c][LO_W-1:0] = ev_data[LO_W-1:0];
                    FLD_HI:  st_d.word[c][DW-1:LO_W] = ev_data[HI_W-1:0];
                    default: st_d.word[c] = ev_data;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words = st_q.word;
    assign stb   = st_q.stb;
    assign chan  = st_q.chan;

    // R7: the report strobe never stays high for two cycles
    p_stb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stb |=> !st_q.stb);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R3: a low-half write leaves the high half alone
        p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_vld && ev_chan == CHW'(g) && ev_fld == FLD_LO)
            |=> $stable(st_q.word[g][DW-1:LO_W]));
        // R4: a high-half write leaves the low half alone
        p_hi_keeps_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_vld && ev_chan == CHW'(g) && ev_fld == FLD_HI)
            |=> $stable(st_q.word[g][LO_W-1:0]));
        // R8: a word not targeted by an event holds its value
        p_other_ch_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(ev_vld && ev_chan == CHW'(g)) |=> $stable(st_q.word[g]));
    end
endmodule

// File: rtl/dac_quad_loader.sv
module dac_quad_loader
    import dacld_pkg::*;
#(
    parameter int DW     = 14,
    parameter int LO_W   = 8,
    parameter int AW     = 3,
    parameter int NCH    = 4,
    parameter int STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    wr_n,
    input  logic [AW-1:0]           chan_addr,
    input  logic                    byte_mode,
    input  logic                    hi_sel,
    input  logic [DW-1:0]           din,
    output logic [NCH*DW-1:0]       dac_words,
    output logic                    wr_stb,
    output logic [$clog2(NCH)-1:0]  wr_chan
);
    localparam int CHW = $clog2(NCH);
    localparam int WB  = 4 + AW + DW;

    logic [WB-1:0]  bus_raw, bus_sync;
    logic           ev_vld;
    logic [CHW-1:0] ev_chan;
    fld_e           ev_fld;
    logic [DW-1:0]  ev_data;

    assign bus_raw = {wr_n, cs_n, byte_mode, hi_sel, chan_addr, din};

    dacld_sync #(.WB(WB), .STAGES(STAGES), .RST_VAL({WB{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (bus_raw),
        .d_out (bus_sync)
    );

    dacld_decode #(.DW(DW), .AW(AW), .NCH(NCH)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp     (bus_sync),
        .ev_vld  (ev_vld),
        .ev_chan (ev_chan),
        .ev_fld  (ev_fld),
        .ev_data (ev_data)
    );

    dacld_bank #(.DW(DW), .LO_W(LO_W), .NCH(NCH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_vld  (ev_vld),
        .ev_chan (ev_chan),
        .ev_fld  (ev_fld),
        .ev_data (ev_data),
        .words   (dac_words),
        .stb     (wr_stb),
        .chan    (wr_chan)
    );

    // R7: every report strobe follows an event one cycle earlier
    p_stb_after_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_stb) |-> $past(ev_vld));
endmodule

// File: tb/dac_quad_loader_tb.sv
module dac_quad_loader_tb;
    localparam int CLK_P = 10;
    localparam int DW    = 14;
    localparam int NCH   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [2:0]    chan_addr = '0;
    logic          byte_mode = 1'b0;
    logic          hi_sel = 1'b0;
    logic [DW-1:0] din = '0;
    logic [NCH*DW-1:0] dac_words;
    logic          wr_stb;
    logic [1:0]    wr_chan;

    always #(CLK_P/2) clk = ~clk;

    dac_quad_loader u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .chan_addr(chan_addr), .byte_mode(byte_mode), .hi_sel(hi_sel),
        .din(din), .dac_words(dac_words), .wr_stb(wr_stb), .wr_chan(wr_chan)
    );

    typedef struct packed {
        logic [1:0]    chan;
        logic [DW-1:0] word;
    } exp_t;

    exp_t          expq[$];
    logic [DW-1:0] model [NCH];
    int            n_chk = 0;
    int            n_err = 0;
    int            stb_cnt = 0;
    logic          stb_prev = 1'b0;
    bit            done = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pairs each strobe with the oldest expected write
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb) begin
                stb_cnt++;
                check("R7 pulse width", {31'd0, stb_prev}, 32'd0);
                if (expq.size() == 0) begin
                    check("R5/R6 unexpected strobe", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check("R7 channel", {30'd0, wr_chan}, {30'd0, e.chan});
                    check("R2/R3/R4 word", {18'd0, dac_words[e.chan*DW +: DW]}, {18'd0, e.word});
                end
            end
            stb_prev = wr_stb;
        end
    end

    task automatic check_all(input string req);
        for (int c = 0; c < NCH; c++) begin
            check(req, {18'd0, dac_words[c*DW +: DW]}, {18'd0, model[c]});
        end
    endtask

    // driver: one bus write, with the expectation pushed when accepted
    task automatic do_write(input logic cs, input int a, input logic bm,
                            input logic hs, input logic [DW-1:0] d, input int low_cycles);
        @(negedge clk);
        cs_n = ~cs; chan_addr = 3'(a); byte_mode = bm; hi_sel = hs; din = d;
        wr_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        if (cs && a < NCH) begin
            if (!bm)     model[a] = d;
            else if (hs) model[a][13:8] = d[5:0];
            else         model[a][7:0] = d[7:0];
            expq.push_back({2'(a), model[a]});
        end
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int s0;
        for (int c = 0; c < NCH; c++) model[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_all("R1 reset word");
        check("R1 reset strobe", {31'd0, wr_stb}, 32'd0);

        // R2 full writes on every channel
        do_write(1, 0, 0, 0, 14'h3FFF, 3);
        do_write(1, 1, 0, 0, 14'h1234, 3);
        do_write(1, 2, 0, 0, 14'h2AAA, 3);
        do_write(1, 3, 0, 0, 14'h0001, 3);
        check_all("R2/R8 after full writes");

        // R3 low half, upper din bits must be dropped
        do_write(1, 1, 1, 0, 14'h3F5A, 3);
        check("R3 low half", {18'd0, dac_words[1*DW +: DW]}, 32'h125A);
        do_write(1, 2, 1, 0, 14'h3FC3, 3);
        check("R3 low half keep high", {18'd0, dac_words[2*DW +: DW]}, 32'h2AC3);

        // R4 high half, din[13:6] must be dropped
        do_write(1, 1, 1, 1, 14'h3FFF, 3);
        check("R4 high half", {18'd0, dac_words[1*DW +: DW]}, 32'h3F5A);
        do_write(1, 3, 1, 1, 14'h3FC0, 3);
        check("R4 high zero keep low", {18'd0, dac_words[3*DW +: DW]}, 32'h0001);
        check_all("R8 other channels");

        // R5 out-of-range addresses
        s0 = stb_cnt;
        for (int a = 4; a < 8; a++) do_write(1, a, 0, 0, 14'h0000, 3);
        check("R5 no strobe", stb_cnt - s0, 32'd0);
        check_all("R5 words unchanged");

        // R6 chip select inactive
        s0 = stb_cnt;
        do_write(0, 0, 0, 0, 14'h0000, 3);
        do_write(0, 2, 1, 1, 14'h0000, 3);
        check("R6 no strobe", stb_cnt - s0, 32'd0);
        check_all("R6 words unchanged");

        // R9 long low strobe: nothing until the rising edge, then one write
        s0 = stb_cnt;
        @(negedge clk);
        cs_n = 1'b0; chan_addr = 3'd2; byte_mode = 1'b0; din = 14'h0777;
        wr_n = 1'b0;
        repeat (20) @(negedge clk);
        check("R9 no write while low", stb_cnt - s0, 32'd0);
        check("R9 word held while low", {18'd0, dac_words[2*DW +: DW]}, {18'd0, model[2]});
        model[2] = 14'h0777;
        expq.push_back({2'd2, model[2]});
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R9 single write", stb_cnt - s0, 32'd1);

        // R7 latency: word appears exactly at the third edge after wr_n rises
        @(negedge clk);
        cs_n = 1'b0; chan_addr = 3'd0; byte_mode = 1'b0; din = 14'h0ABC;
        wr_n = 1'b0;
        repeat (3) @(negedge clk);
        model[0] = 14'h0ABC;
        expq.push_back({2'd0, model[0]});
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 not early", {18'd0, dac_words[0 +: DW]}, 32'h3FFF);
        @(negedge clk);
        check("R7 on time", {18'd0, dac_words[0 +: DW]}, 32'h0ABC);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);

        check_all("R8 final words");
        check("R7 queue drained", expq.size(), 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule